// File: doc/BRIEF.md
# Per-Thread Interrupt Presenter Register Window

This block is the register window that one processor thread uses to see and handle its interrupts. It sits on a simple memory-mapped bus with a 12-bit address, a size code, separate read and write strobes, and 32-bit big-endian data. Inside it holds the thread's current priority mask, an inter-processor interrupt request priority, the number of the source now being presented, and three general-purpose link words.

One pending external source (number plus priority) arrives on input pins. Each cycle the block compares that source and the inter-processor request against the current priority mask, and shows the winner in the pending-source field and on `irq_out`. The thread polls without side effects, claims the interrupt with a 32-bit read of the claim register, and hands it back with a 32-bit write to the same address. A byte access to that address reaches only the priority mask byte. Illegal sizes and unmapped addresses raise a one-cycle error flag, read back as all ones, and change nothing.

Top module: `irq_presenter_front`

## Requirements
- R1: Registers are selected by `bus_addr[11:2]`. Word index 0 is poll, 1 is claim, 3 is the inter-processor priority, and 4, 5 and 6 are link words 0, 1 and 2. The status word reads as {mask[7:0], source[23:0]}. A byte travels in lane 0, which is data bits [31:24]. Byte reads return zero in bits [23:0].
- R2: A word read at index 0 returns the status word. A byte read there returns the mask byte. Neither changes any state.
- R3: A word read at index 1 returns the status word and claims the interrupt. The mask takes the presented priority, the source field clears and `irq_out` falls. If nothing is presented, the mask is left as it was. A byte read at index 1 returns the mask byte and has no side effect.
- R4: A byte write at index 1 loads the mask from `bus_wdata[31:24]`. A word write at index 1 is an end-of-interrupt: it loads the mask from `bus_wdata[31:24]` and lets presentation be evaluated again.
- R5: The inter-processor priority at index 3 can be read and written by byte access only. It changes on no other access.
- R6: The three link words accept only word reads and writes. They store 32 bits and have no effect on presentation.
- R7: Size codes are 00 for byte and 10 for word; 01 and 11 are illegal. A byte access whose `bus_addr[1:0]` is not 0 is illegal. So is any size a register does not accept, a write at index 0, and any unmapped index. An illegal read returns 32'hFFFFFFFF. An illegal write changes nothing. Either one sets `bus_err` for one cycle.
- R8: A request is presented only if its priority is numerically lower than the mask. The inter-processor request appears as source 2 and wins a priority tie against the external source. Priority 8'hFF is never presented. The source field and `irq_out` follow the inputs one cycle later.
- R9: After reset the mask is 8'h00, the inter-processor priority is 8'hFF, the source field is 0, `irq_out` is low, the link words are 0, and `bus_rdata` and `bus_err` are 0.
- R10: A cycle with `bus_rd` high is a read; a cycle with only `bus_wr` high is a write. `bus_rdata` and `bus_err` appear in the cycle after the access. `bus_rdata` is 0 after a cycle that is not a read, and `bus_err` is low after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_size | input | 2 | Access size code (00 byte, 10 word) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, big-endian |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | Illegal access flag, one cycle after the access |
| ext_src | input | 24 | Number of the pending external source |
| ext_prio | input | 8 | Priority of the pending external source (FF = none) |
| irq_out | output | 1 | Interrupt request to the thread |

## Verification
The hardest case to reach from the ports is a claim that lands in the same cycle the presentation is about to change. Examples are a tie between the inter-processor request and the external source, a claim with nothing presented, or a mask write that drops a request that is already presented. Directed steps set up each of these: the mask is set first, the inter-processor priority is made equal to the external one, and the claim is issued at once. A long random run then mixes mapped and unmapped addresses, all four size codes, misaligned low address bits and changing external requests, and compares every cycle against a reference model in the bench.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam int IDX_POLL  = 0;
  localparam int IDX_CLAIM = 1;
  localparam int IDX_IPI   = 3;

  typedef enum logic [2:0] {
    SEL_POLL,
    SEL_CLAIM,
    SEL_IPI,
    SEL_LINK,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/irqp_decode.sv
module irqp_decode
  import irqp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LINKS = 3,
  parameter int LINK_BASE = 4,
  parameter int LIDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic [LIDX_W-1:0] link_idx,
  output logic              is_word,
  output logic              legal
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] LINK_LO = WIDX_W'(LINK_BASE);
  localparam logic [WIDX_W-1:0] LINK_HI = WIDX_W'(LINK_BASE + NUM_LINKS);

  logic [WIDX_W-1:0] widx;
  logic              byte_ok;

  assign widx    = addr[ADDR_W-1:2];
  assign byte_ok = (size == SZ_BYTE) && (addr[1:0] == 2'b00);
  assign is_word = (size == SZ_WORD);

  always_comb begin
    sel      = SEL_NONE;
    legal    = 1'b0;
    link_idx = '0;
    if (widx == WIDX_W'(IDX_POLL)) begin
      sel   = SEL_POLL;
      legal = rd && (byte_ok || is_word);
    end else if (widx == WIDX_W'(IDX_CLAIM)) begin
      sel   = SEL_CLAIM;
      legal = byte_ok || is_word;
    end else if (widx == WIDX_W'(IDX_IPI)) begin
      sel   = SEL_IPI;
      legal = byte_ok;
    end else if (widx >= LINK_LO && widx < LINK_HI) begin
      sel      = SEL_LINK;
      legal    = is_word;
      link_idx = LIDX_W'(widx - LINK_LO);
    end
  end
endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic [PRIO_W-1:0] mask,
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [PRIO_W-1:0] ext_prio,
  input  logic [SRC_W-1:0]  ext_src,
  output logic              cand_valid,
  output logic [SRC_W-1:0]  cand_src,
  output logic [PRIO_W-1:0] cand_prio
);
  logic ipi_ok;
  logic ext_ok;

  assign ipi_ok = ipi_prio < mask;
  assign ext_ok = ext_prio < mask;

  always_comb begin
    cand_valid = 1'b0;
    cand_src   = '0;
    cand_prio  = '1;
    if (ipi_ok && (!ext_ok || ipi_prio <= ext_prio)) begin
      cand_valid = 1'b1;
      cand_src   = SRC_W'(IPI_SRC);
      cand_prio  = ipi_prio;
    end else if (ext_ok) begin
      cand_valid = 1'b1;
      cand_src   = ext_src;
      cand_prio  = ext_prio;
    end
  end
endmodule

// File: rtl/irqp_links.sv
module irqp_links #(
  parameter int NUM_LINKS = 3,
  parameter int DATA_W    = 32,
  parameter int LIDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] link_q [NUM_LINKS];

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    logic              hit;
    logic [DATA_W-1:0] link_d;
    assign hit = wr_en && (idx == LIDX_W'(g));
    always_comb begin
      link_d = link_q[g];
      if (hit) link_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) link_q[g] <= '0;
      else        link_q[g] <= link_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (idx == LIDX_W'(i)) rd_data = link_q[i];
    end
  end
endmodule

// File: rtl/irq_presenter_front.sv
module irq_presenter_front
  import irqp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PRIO_W    = 8,
  parameter int SRC_W     = 24,
  parameter int NUM_LINKS = 3,
  parameter int LINK_BASE = 4,
  parameter int IPI_SRC   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [1:0]                bus_size,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [PRIO_W+SRC_W-1:0]   bus_wdata,
  output logic [PRIO_W+SRC_W-1:0]   bus_rdata,
  output logic                      bus_err,
  input  logic [SRC_W-1:0]          ext_src,
  input  logic [PRIO_W-1:0]         ext_prio,
  output logic                      irq_out
);
  localparam int DATA_W = PRIO_W + SRC_W;
  localparam int LIDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  reg_sel_e          sel;
  logic [LIDX_W-1:0] link_idx;
  logic              is_word;
  logic              legal;

  irqp_decode #(
    .ADDR_W(ADDR_W), .NUM_LINKS(NUM_LINKS), .LINK_BASE(LINK_BASE), .LIDX_W(LIDX_W)
  ) u_decode (
    .addr(bus_addr), .size(bus_size), .rd(bus_rd),
    .sel(sel), .link_idx(link_idx), .is_word(is_word), .legal(legal)
  );

  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic [SRC_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pprio_q, pprio_d;
  logic              pres_q, pres_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  logic              cand_valid;
  logic [SRC_W-1:0]  cand_src;
  logic [PRIO_W-1:0] cand_prio;

  irqp_arbiter #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_arb (
    .mask(cppr_q), .ipi_prio(mfrr_q), .ext_prio(ext_prio), .ext_src(ext_src),
    .cand_valid(cand_valid), .cand_src(cand_src), .cand_prio(cand_prio)
  );

  logic              rd_cyc, wr_cyc, ok_rd, ok_wr, do_claim, link_we;
  logic [DATA_W-1:0] link_rd;
  logic [DATA_W-1:0] status;
  logic [PRIO_W-1:0] wr_byte;

  assign rd_cyc   = bus_rd;
  assign wr_cyc   = bus_wr && !bus_rd;
  assign ok_rd    = rd_cyc && legal;
  assign ok_wr    = wr_cyc && legal;
  assign do_claim = ok_rd && (sel == SEL_CLAIM) && is_word;
  assign link_we  = ok_wr && (sel == SEL_LINK);
  assign status   = {cppr_q, xisr_q};
  assign wr_byte  = bus_wdata[DATA_W-1 -: PRIO_W];

  irqp_links #(.NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .LIDX_W(LIDX_W)) u_links (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(link_we), .idx(link_idx),
    .wdata(bus_wdata), .rd_data(link_rd)
  );

  // read response and error
  always_comb begin
    rdata_d = '0;
    err_d   = (bus_rd || bus_wr) && !legal;
    if (rd_cyc) begin
      if (!legal) begin
        rdata_d = '1;
      end else begin
        unique case (sel)
          SEL_POLL, SEL_CLAIM: rdata_d = is_word ? status : {cppr_q, {SRC_W{1'b0}}};
          SEL_IPI:             rdata_d = {mfrr_q, {SRC_W{1'b0}}};
          SEL_LINK:            rdata_d = link_rd;
          default:             rdata_d = '1;
        endcase
      end
    end
  end

  // priority registers and presentation
  always_comb begin
    cppr_d = cppr_q;
    mfrr_d = mfrr_q;
    if (ok_wr && sel == SEL_CLAIM) cppr_d = wr_byte;
    if (ok_wr && sel == SEL_IPI)   mfrr_d = wr_byte;
    if (do_claim) begin
      if (pres_q) cppr_d = pprio_q;
      xisr_d  = '0;
      pres_d  = 1'b0;
      pprio_d = '1;
    end else begin
      xisr_d  = cand_valid ? cand_src : '0;
      pres_d  = cand_valid;
      pprio_d = cand_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cppr_q  <= '0;
      mfrr_q  <= '1;
      xisr_q  <= '0;
      pprio_q <= '1;
      pres_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      cppr_q  <= cppr_d;
      mfrr_q  <= mfrr_d;
      xisr_q  <= xisr_d;
      pprio_q <= pprio_d;
      pres_q  <= pres_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign irq_out   = pres_q;
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int ADDR_W = 12,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-3:0] widx,
  input logic [1:0]        bus_size,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              irq_out,
  input logic              pres_q,
  input logic [PRIO_W-1:0] cppr_q,
  input logic [PRIO_W-1:0] pprio_q,
  input logic [PRIO_W-1:0] mfrr_q
);
  localparam int WIDX_W = ADDR_W - 2;

  AST_HALF_REJECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_size == 2'b01) |=> (bus_err && bus_rdata == '1)); // R7

  AST_CLAIM_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_size == 2'b10 && widx == WIDX_W'(1)) |=> !irq_out); // R3

  AST_CLAIM_MASK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_size == 2'b10 && widx == WIDX_W'(1) && pres_q) |=> (cppr_q == $past(pprio_q))); // R3

  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_rd || bus_wr) |=> !bus_err); // R10

  AST_NOREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |=> (bus_rdata == '0)); // R10

  AST_IPI_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && !bus_rd && widx == WIDX_W'(3)) |=> $stable(mfrr_q)); // R5
endmodule

bind irq_presenter_front irqp_checker #(
  .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .DATA_W(PRIO_W + SRC_W)
) u_checker (
  .clk(clk), .rst_sync_n(rst_sync_n), .widx(bus_addr[ADDR_W-1:2]),
  .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_out(irq_out),
  .pres_q(pres_q), .cppr_q(cppr_q), .pprio_q(pprio_q), .mfrr_q(mfrr_q)
);

// File: tb/irq_presenter_front_tb.sv
module irq_presenter_front_tb_top;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [23:0] ext_src;
  logic [7:0]  ext_prio;
  logic        irq_out;

  int n_vec;
  int n_bad;
  bit done;

  // reference state
  logic [7:0]  m_cppr, m_mfrr, m_pprio;
  logic [23:0] m_xisr;
  logic        m_pres;
  logic [31:0] m_link [3];

  irq_presenter_front dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .ext_src(ext_src), .ext_prio(ext_prio), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit ref_legal(bit rd, logic [11:0] a, logic [1:0] s);
    bit bo = (s == 2'b00) && (a[1:0] == 2'b00);
    bit wo = (s == 2'b10);
    case (a[11:2])
      10'd0:               return rd && (bo || wo);
      10'd1:               return bo || wo;
      10'd3:               return bo;
      10'd4, 10'd5, 10'd6: return wo;
      default:             return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, compare at the following negedge
  task automatic step(bit rd, bit wr, logic [11:0] a, logic [1:0] s,
                      logic [31:0] wd, logic [7:0] ep, logic [23:0] es, string tag);
    bit          lg, rdc, wrc, claim, cv;
    logic [31:0] e_rd;
    logic        e_err;
    logic [23:0] cs;
    logic [7:0]  cp;
    logic [7:0]  n_cppr, n_mfrr;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = s; bus_wdata = wd;
    ext_prio = ep; ext_src = es;
    rdc   = rd;
    wrc   = wr && !rd;
    lg    = ref_legal(rd, a, s);
    e_err = (rd || wr) && !lg;
    e_rd  = 32'h0;
    if (rdc) begin
      if (!lg) e_rd = 32'hFFFF_FFFF;
      else case (a[11:2])
        10'd0, 10'd1: e_rd = (s == 2'b10) ? {m_cppr, m_xisr} : {m_cppr, 24'h0};
        10'd3:        e_rd = {m_mfrr, 24'h0};
        default:      e_rd = m_link[a[3:2]];
      endcase
    end
    // presentation candidate from pre-edge state
    cv = 1'b0; cs = 24'h0; cp = 8'hFF;
    if (m_mfrr < m_cppr && !(ep < m_cppr && ep < m_mfrr)) begin
      cv = 1'b1; cs = 24'd2; cp = m_mfrr;
    end else if (ep < m_cppr) begin
      cv = 1'b1; cs = es; cp = ep;
    end
    claim  = rdc && lg && a[11:2] == 10'd1 && s == 2'b10;
    n_cppr = m_cppr;
    n_mfrr = m_mfrr;
    if (wrc && lg && a[11:2] == 10'd1) n_cppr = wd[31:24];
    if (wrc && lg && a[11:2] == 10'd3) n_mfrr = wd[31:24];
    if (wrc && lg && a[11:2] >= 10'd4) m_link[a[3:2]] = wd;
    if (claim) begin
      if (m_pres) n_cppr = m_pprio;
      m_xisr = 24'h0; m_pres = 1'b0; m_pprio = 8'hFF;
    end else begin
      m_xisr = cv ? cs : 24'h0; m_pres = cv; m_pprio = cp;
    end
    m_cppr = n_cppr;
    m_mfrr = n_mfrr;
    @(posedge clk);
    @(negedge clk);
    check(tag, "rdata", bus_rdata, e_rd);
    check(tag, "err", {31'h0, bus_err}, {31'h0, e_err});
    check(tag, "irq", {31'h0, irq_out}, {31'h0, m_pres});
  endtask

  task automatic idle(logic [7:0] ep, logic [23:0] es, string tag);
    step(1'b0, 1'b0, 12'h0, 2'b00, 32'h0, ep, es, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] ra;
    n_vec = 0; n_bad = 0; done = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_size = 0;
    bus_wdata = 0; ext_src = 0; ext_prio = 8'hFF;
    m_cppr = 8'h00; m_mfrr = 8'hFF; m_xisr = 0; m_pprio = 8'hFF; m_pres = 0;
    for (int i = 0; i < 3; i++) m_link[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "rdata", bus_rdata, 32'h0);
    check("R9", "err", {31'h0, bus_err}, 32'h0);
    check("R9", "irq", {31'h0, irq_out}, 32'h0);
    step(1, 0, 12'h00C, 2'b00, 0, 8'hFF, 0, "R9 ipi reset FF");
    step(1, 0, 12'h000, 2'b10, 0, 8'hFF, 0, "R9 status zero");
    step(1, 0, 12'h010, 2'b10, 0, 8'hFF, 0, "R9 link zero");
    // R4 byte write of mask, R2 poll
    step(0, 1, 12'h004, 2'b00, 32'hFF00_0000, 8'hFF, 0, "R4 mask byte write");
    step(1, 0, 12'h000, 2'b00, 0, 8'hFF, 0, "R2 poll byte");
    // R8 external presented
    idle(8'h40, 24'h000123, "R8 ext present");
    step(1, 0, 12'h000, 2'b10, 0, 8'h40, 24'h000123, "R2 poll word");
    step(1, 0, 12'h000, 2'b10, 0, 8'h40, 24'h000123, "R2 poll no side effect");
    // R8 tie: ipi wins
    step(0, 1, 12'h00C, 2'b00, 32'h4000_0000, 8'h40, 24'h000123, "R5 ipi write");
    idle(8'h40, 24'h000123, "R8 ipi wins tie");
    step(1, 0, 12'h000, 2'b10, 0, 8'h40, 24'h000123, "R8 ipi source 2");
    // R3 byte read no claim, then claim
    step(1, 0, 12'h004, 2'b00, 0, 8'h40, 24'h000123, "R3 byte read no claim");
    step(1, 0, 12'h004, 2'b10, 0, 8'h40, 24'h000123, "R3 claim");
    step(1, 0, 12'h000, 2'b10, 0, 8'h40, 24'h000123, "R3 after claim");
    // R4 end of interrupt
    step(0, 1, 12'h00C, 2'b00, 32'hFF00_0000, 8'h40, 24'h000123, "R5 ipi clear");
    step(0, 1, 12'h004, 2'b10, 32'hFF00_0002, 8'h40, 24'h000123, "R4 eoi");
    idle(8'h40, 24'h000123, "R4 reeval");
    step(1, 0, 12'h000, 2'b10, 0, 8'h40, 24'h000123, "R4 ext back");
    // R1 lane: mask write with low bytes set
    step(0, 1, 12'h004, 2'b00, 32'h3012_3456, 8'h40, 24'h000123, "R1 lane0 write");
    step(1, 0, 12'h000, 2'b10, 0, 8'h40, 24'h000123, "R1 status layout");
    // R6 links
    step(0, 1, 12'h010, 2'b10, 32'hDEAD_BEEF, 8'hFF, 0, "R6 link0 write");
    step(0, 1, 12'h014, 2'b10, 32'h1234_5678, 8'hFF, 0, "R6 link1 write");
    step(0, 1, 12'h018, 2'b10, 32'hA5A5_0F0F, 8'hFF, 0, "R6 link2 write");
    step(1, 0, 12'h010, 2'b10, 0, 8'hFF, 0, "R6 link0 read");
    step(1, 0, 12'h014, 2'b10, 0, 8'hFF, 0, "R6 link1 read");
    step(1, 0, 12'h018, 2'b10, 0, 8'hFF, 0, "R6 link2 read");
    step(1, 0, 12'h010, 2'b00, 0, 8'hFF, 0, "R6 link byte illegal");
    // R7 illegal accesses
    step(1, 0, 12'h000, 2'b01, 0, 8'hFF, 0, "R7 half size");
    step(1, 0, 12'h004, 2'b11, 0, 8'hFF, 0, "R7 size 11");
    step(1, 0, 12'h005, 2'b00, 0, 8'hFF, 0, "R7 misaligned byte");
    step(0, 1, 12'h00C, 2'b10, 32'h1000_0000, 8'hFF, 0, "R7 ipi word write");
    step(1, 0, 12'h00C, 2'b00, 0, 8'hFF, 0, "R7 ipi unchanged");
    step(0, 1, 12'h000, 2'b10, 32'h0000_0000, 8'hFF, 0, "R7 poll write");
    step(1, 0, 12'h000, 2'b10, 0, 8'hFF, 0, "R7 mask unchanged");
    step(1, 0, 12'h100, 2'b10, 0, 8'hFF, 0, "R7 unmapped read");
    step(0, 1, 12'h01C, 2'b10, 32'h1, 8'hFF, 0, "R7 unmapped write");
    step(0, 1, 12'h014, 2'b00, 32'h7700_0000, 8'hFF, 0, "R7 link byte write");
    step(1, 0, 12'h014, 2'b10, 0, 8'hFF, 0, "R7 link unchanged");
    // R3 claim with nothing presented; R8 FF never presented
    step(0, 1, 12'h004, 2'b00, 32'hFF00_0000, 8'hFF, 24'h55, "R8 mask FF");
    idle(8'hFF, 24'h55, "R8 FF not presented");
    step(1, 0, 12'h004, 2'b10, 0, 8'hFF, 24'h55, "R3 empty claim");
    step(1, 0, 12'h000, 2'b00, 0, 8'hFF, 24'h55, "R3 mask kept");
    // R10 simultaneous strobes act as read
    step(1, 1, 12'h004, 2'b00, 32'h0100_0000, 8'hFF, 0, "R10 rd and wr");
    step(1, 0, 12'h004, 2'b00, 0, 8'hFF, 0, "R10 write dropped");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int  k;
      bit  rd, wr;
      logic [1:0] sz;
      k  = $urandom_range(0, 9);
      ra = (k < 8) ? 12'(k * 4) : 12'($urandom_range(0, 4095));
      if ($urandom_range(0, 7) == 0) ra[1:0] = 2'($urandom_range(1, 3));
      sz = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3))
                                       : (($urandom_range(0, 1) == 1) ? 2'b10 : 2'b00);
      rd = ($urandom_range(0, 2) == 0);
      wr = !rd && ($urandom_range(0, 1) == 1);
      step(rd, wr, ra, sz, $urandom(), 8'($urandom_range(0, 255)),
           24'($urandom_range(3, 1000)), "R7/R8 random");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule